// File: doc/BRIEF.md
# Timestamped Event Sequence Player

This block replays a table of timed events on the event clock. Each table slot holds an event code, a timestamp counted from the start of the sequence, and two small groups of mask bits. A host fills the table through a simple write port. After a trigger, a free-running position counter starts from zero. Whenever the counter has reached or passed the timestamp of the slot under the read pointer, that slot is consumed and the pointer moves on.

Two code values are never sent. One is a filler code, used to bridge gaps longer than the counter range. The other marks the end of the table. What happens at the end marker depends on the selected mode: stop and drop the enable, loop straight back to the start, or park and wait for another trigger. The host controls the block through enable, disable and reset strobes. Single-cycle interrupt pulses report sequence start, sequence stop, the pointer reaching the middle of the table, and the pointer wrapping past its last slot.

Top module: `seq_player`

## Requirements
- R1: The table holds 2**ADDR_W slots. A host write stores the code, timestamp, four-bit enable mask and four-bit disable mask at the given slot, and that content is what a later replay uses.
- R2: An accepted trigger clears no state and starts the counter, which then increments once per clock. While running, the slot under the pointer is consumed in the first clock where counter >= its timestamp, with unsigned compare. A consumed slot that is not suppressed raises evValid with its code in the next clock. Slots with consecutive timestamps are sent on consecutive clocks.
- R3: The counter is TS_W bits wide and wraps from all ones to zero, so a gap between slots can be bridged with a filler slot whose timestamp is all ones.
- R4: Code 0x00 (filler) and code 0x7F (end marker) are consumed but never appear on evValid/evCode.
- R5: With mode 0 (mode 3 acts the same), the end marker clears the pointer and counter and stops the run. It also drops the enable, so a later trigger is ignored until the host enables again.
- R6: With mode 1, the end marker clears the pointer and counter and the next pass begins on the following clock without a trigger.
- R7: With mode 2, the end marker clears the pointer and counter and stops the run. The block stays enabled, so the next trigger starts a new pass.
- R8: ctlEnable sets the enable. ctlDisable stops the run and clears the enable but keeps the pointer and counter, so the next enable and trigger resume from the same place. ctlReset does the same and also clears the pointer and counter. Priority is ctlReset over ctlDisable over ctlEnable.
- R9: irqStart pulses for one clock after a trigger is accepted while enabled and idle. irqStop pulses together with the slot timing when a running sequence consumes the end marker.
- R10: irqHalf pulses when the pointer advances from slot 2**ADDR_W/2-1 to the middle slot. irqRoll pulses when it advances from the last slot back to slot 0.
- R11: Bit k of the enable mask, when set, lets the slot out only if hwMask[k] or swMask[k] is high. Bit k of the disable mask, when set, blocks the slot if hwMask[k] or swMask[k] is high. A blocked slot is still consumed.
- R12: A trigger while running, or while not enabled, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | ADDR_W | Table slot to write |
| wrCode | input | 8 | Event code for the slot |
| wrTs | input | TS_W | Timestamp for the slot |
| wrEnMask | input | MASK_N | Enable-mask bits for the slot |
| wrDisMask | input | MASK_N | Disable-mask bits for the slot |
| ctlEnable | input | 1 | Write-one strobe: enable |
| ctlDisable | input | 1 | Write-one strobe: disable, keep position |
| ctlReset | input | 1 | Write-one strobe: disable and clear position |
| trigger | input | 1 | Start request |
| mode | input | 2 | End behaviour: 0 single, 1 recycle, 2 retrigger, 3 single |
| hwMask | input | MASK_N | Hardware mask signals |
| swMask | input | MASK_N | Software mask bits |
| evValid | output | 1 | Event code valid strobe |
| evCode | output | 8 | Emitted event code |
| irqStart | output | 1 | Sequence start pulse |
| irqStop | output | 1 | Sequence stop pulse |
| irqHalf | output | 1 | Middle-of-table pulse |
| irqRoll | output | 1 | Pointer wrap pulse |

## Verification
The assertions assume the following about the host. It gives each control strobe for a single clock. It never gives ctlEnable in the same clock as an end marker is consumed. It changes a table slot only while the sequence is idle, and at least two clocks before the next trigger, because the table output has one clock of read latency. The stimulus writes the table with the block stopped, waits two idle clocks before each trigger, changes mode and mask inputs only while idle, and applies enable and reset together only in the one case that exercises their priority.

// File: rtl/seq_player_pkg.sv
`timescale 1ns/1ps
package seq_player_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_FILL = 8'h00;
  localparam logic [CODE_W-1:0] CODE_END  = 8'h7F;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_RECYCLE = 2'd1,
    MODE_RETRIG  = 2'd2,
    MODE_SINGLE2 = 2'd3
  } seqMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic step;   // advance counter, evaluate current slot
    logic clear;  // return pointer and counter to zero
  } seqStrobe_t;
endpackage

// File: rtl/seq_table_ram.sv
`timescale 1ns/1ps
module seq_table_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 56
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/seq_datapath.sv
`timescale 1ns/1ps
module seq_datapath
  import seq_player_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int TS_W   = 32,
  parameter int MASK_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CODE_W-1:0] wrCode,
  input  logic [TS_W-1:0]   wrTs,
  input  logic [MASK_N-1:0] wrEnMask,
  input  logic [MASK_N-1:0] wrDisMask,
  input  logic [MASK_N-1:0] hwMask,
  input  logic [MASK_N-1:0] swMask,
  output logic              hit,
  output logic              hitEnd,
  output logic              evValid,
  output logic [CODE_W-1:0] evCode,
  output logic              irqHalf,
  output logic              irqRoll
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int ENT_W = 2 * MASK_N + CODE_W + TS_W;
  localparam logic [ADDR_W-1:0] PTR_HALF_PRE = ADDR_W'(HALF - 1);
  localparam logic [ADDR_W-1:0] PTR_LAST     = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr, ptrNext;
  logic [TS_W-1:0]   cnt;
  logic [ENT_W-1:0]  wrEntry, curEntry;
  logic [MASK_N-1:0] entDis, entEn, maskSrc, bitOk;
  logic [CODE_W-1:0] entCode;
  logic [TS_W-1:0]   entTs;
  logic              maskPass, emitNow, advance;

  assign wrEntry = {wrDisMask, wrEnMask, wrCode, wrTs};
  assign {entDis, entEn, entCode, entTs} = curEntry;

  // read address is the next pointer, so curEntry always matches ptr
  seq_table_ram #(.ADDR_W(ADDR_W), .DATA_W(ENT_W)) table_i (
    .clk    (clk),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrEntry),
    .rdAddr (ptrNext),
    .rdData (curEntry)
  );

  assign maskSrc = hwMask | swMask;

  for (genvar k = 0; k < MASK_N; k++) begin : g_mask
    assign bitOk[k] = (!entEn[k] || maskSrc[k]) && !(entDis[k] && maskSrc[k]);
  end
  assign maskPass = &bitOk;

  assign hit     = strobe.step && (cnt >= entTs);
  assign hitEnd  = hit && (entCode == CODE_END);
  assign advance = hit && !hitEnd;
  assign emitNow = advance && (entCode != CODE_FILL) && maskPass;

  always_comb begin
    if (strobe.clear)  ptrNext = '0;
    else if (advance)  ptrNext = ptr + 1'b1;
    else               ptrNext = ptr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      cnt     <= '0;
      evValid <= 1'b0;
      evCode  <= '0;
      irqHalf <= 1'b0;
      irqRoll <= 1'b0;
    end else begin
      ptr     <= ptrNext;
      if (strobe.clear)     cnt <= '0;
      else if (strobe.step) cnt <= cnt + 1'b1;
      evValid <= emitNow;
      if (emitNow) evCode <= entCode;
      irqHalf <= advance && (ptr == PTR_HALF_PRE);
      irqRoll <= advance && (ptr == PTR_LAST);
    end
  end

  AST_EMIT_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> (evCode != CODE_FILL && evCode != CODE_END)); // R4
  AST_EMIT_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> $past(strobe.step)); // R2
  AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.clear && (&cnt)) |=> (cnt == '0)); // R3
  AST_ROLL_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    irqRoll |-> (ptr == '0)); // R10
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.clear) |=> ($stable(ptr) && $stable(cnt))); // R8
endmodule

// File: rtl/seq_control.sv
`timescale 1ns/1ps
module seq_control
  import seq_player_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlEnable,
  input  logic       ctlDisable,
  input  logic       ctlReset,
  input  logic       trigger,
  input  logic [1:0] mode,
  input  logic       hit,
  input  logic       hitEnd,
  output seqStrobe_t strobe,
  output logic       irqStart,
  output logic       irqStop
);
  logic     enabled, running;
  seqMode_e modeE;

  assign modeE = seqMode_e'(mode);

  assign strobe.step  = running && !ctlDisable && !ctlReset;
  assign strobe.clear = ctlReset || hitEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled  <= 1'b0;
      running  <= 1'b0;
      irqStart <= 1'b0;
      irqStop  <= 1'b0;
    end else begin
      irqStart <= 1'b0;
      irqStop  <= 1'b0;
      if (ctlReset || ctlDisable) begin
        enabled <= 1'b0;
        running <= 1'b0;
      end else begin
        if (ctlEnable) enabled <= 1'b1;
        if (running) begin
          if (hitEnd) begin
            irqStop <= 1'b1;
            unique case (modeE)
              MODE_RECYCLE: running <= 1'b1;
              MODE_RETRIG:  running <= 1'b0;
              default: begin
                running <= 1'b0;
                enabled <= 1'b0;
              end
            endcase
          end
        end else if (enabled && trigger) begin
          running  <= 1'b1;
          irqStart <= 1'b1;
        end
      end
    end
  end

  AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> running); // R2
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    irqStart |-> $past(enabled && !running)); // R9
  AST_SINGLE_DROPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (hitEnd && (modeE == MODE_SINGLE || modeE == MODE_SINGLE2)) |=> (!enabled && !running)); // R5
  AST_RECYCLE_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (hitEnd && modeE == MODE_RECYCLE) |=> running); // R6
  AST_RETRIG_KEEPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (hitEnd && modeE == MODE_RETRIG) |=> (enabled && !running)); // R7
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ctlReset |=> !enabled); // R8
endmodule

// File: rtl/seq_player.sv
`timescale 1ns/1ps
module seq_player
  import seq_player_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int TS_W   = 32,
  parameter int MASK_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrCode,
  input  logic [TS_W-1:0]   wrTs,
  input  logic [MASK_N-1:0] wrEnMask,
  input  logic [MASK_N-1:0] wrDisMask,
  input  logic              ctlEnable,
  input  logic              ctlDisable,
  input  logic              ctlReset,
  input  logic              trigger,
  input  logic [1:0]        mode,
  input  logic [MASK_N-1:0] hwMask,
  input  logic [MASK_N-1:0] swMask,
  output logic              evValid,
  output logic [7:0]        evCode,
  output logic              irqStart,
  output logic              irqStop,
  output logic              irqHalf,
  output logic              irqRoll
);
  seqStrobe_t strobe;
  logic       hit, hitEnd;

  seq_control ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctlEnable  (ctlEnable),
    .ctlDisable (ctlDisable),
    .ctlReset   (ctlReset),
    .trigger    (trigger),
    .mode       (mode),
    .hit        (hit),
    .hitEnd     (hitEnd),
    .strobe     (strobe),
    .irqStart   (irqStart),
    .irqStop    (irqStop)
  );

  seq_datapath #(.ADDR_W(ADDR_W), .TS_W(TS_W), .MASK_N(MASK_N)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrCode    (wrCode),
    .wrTs      (wrTs),
    .wrEnMask  (wrEnMask),
    .wrDisMask (wrDisMask),
    .hwMask    (hwMask),
    .swMask    (swMask),
    .hit       (hit),
    .hitEnd    (hitEnd),
    .evValid   (evValid),
    .evCode    (evCode),
    .irqHalf   (irqHalf),
    .irqRoll   (irqRoll)
  );
endmodule

// File: tb/seq_player_tb_top.sv
`timescale 1ns/1ps
module seq_player_tb_top;
  localparam int ADDR_W = 5;
  localparam int TS_W   = 8;
  localparam int MASK_N = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TSMOD  = 1 << TS_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrCode = '0;
  logic [TS_W-1:0] wrTs = '0;
  logic [MASK_N-1:0] wrEnMask = '0, wrDisMask = '0, hwMask = '0, swMask = '0;
  logic ctlEnable = 0, ctlDisable = 0, ctlReset = 0, trigger = 0;
  logic [1:0] mode = 2'd0;
  logic evValid, irqStart, irqStop, irqHalf, irqRoll;
  logic [7:0] evCode;

  always #5 clk = ~clk;

  seq_player #(.ADDR_W(ADDR_W), .TS_W(TS_W), .MASK_N(MASK_N)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCode(wrCode),
    .wrTs(wrTs), .wrEnMask(wrEnMask), .wrDisMask(wrDisMask),
    .ctlEnable(ctlEnable), .ctlDisable(ctlDisable), .ctlReset(ctlReset),
    .trigger(trigger), .mode(mode), .hwMask(hwMask), .swMask(swMask),
    .evValid(evValid), .evCode(evCode), .irqStart(irqStart), .irqStop(irqStop),
    .irqHalf(irqHalf), .irqRoll(irqRoll));

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCode[DEPTH], mTs[DEPTH], mEnM[DEPTH], mDisM[DEPTH];
  bit mEn = 0, mRun = 0;
  int mPtr = 0, mCnt = 0;
  bit eValid = 0, eStart = 0, eStop = 0, eHalf = 0, eRoll = 0;
  int eCode = 0;

  function automatic bit maskOk(int en, int dis);
    for (int k = 0; k < MASK_N; k++) begin
      bit s = hwMask[k] | swMask[k];
      if (en[k] && !s) return 0;
      if (dis[k] && s) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    eValid = 0; eStart = 0; eStop = 0; eHalf = 0; eRoll = 0;
    if (!rstN) begin
      mEn = 0; mRun = 0; mPtr = 0; mCnt = 0;
    end else begin
      if (ctlReset) begin
        mEn = 0; mRun = 0; mPtr = 0; mCnt = 0;
      end else if (ctlDisable) begin
        mEn = 0; mRun = 0;
      end else begin
        if (ctlEnable) mEn = 1;
        if (mRun) begin
          if (mCnt >= mTs[mPtr]) begin
            if (mCode[mPtr] == 8'h7F) begin
              eStop = 1; mPtr = 0; mCnt = 0;
              if (mode == 2'd2) mRun = 0;
              else if (mode != 2'd1) begin mRun = 0; mEn = 0; end
            end else begin
              if (mCode[mPtr] != 0 && maskOk(mEnM[mPtr], mDisM[mPtr])) begin
                eValid = 1; eCode = mCode[mPtr];
              end
              if (mPtr == DEPTH/2 - 1) eHalf = 1;
              if (mPtr == DEPTH - 1) eRoll = 1;
              mPtr = (mPtr + 1) % DEPTH;
              mCnt = (mCnt + 1) % TSMOD;
            end
          end else mCnt = (mCnt + 1) % TSMOD;
        end else if (mEn && trigger) begin
          mRun = 1; eStart = 1;
        end
      end
      if (wrEn) begin
        mCode[wrAddr] = wrCode; mTs[wrAddr] = wrTs;
        mEnM[wrAddr] = wrEnMask; mDisM[wrAddr] = wrDisMask;
      end
    end
  end

  // ---------------- per-cycle compare and capture ----------------
  logic [7:0] gotQ[$];
  logic [7:0] expQ[$];
  int nStart = 0, nStop = 0, nHalf = 0, nRoll = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(evValid == eValid, "R2", "evValid vs model", evValid, eValid);
      if (eValid) check(evCode == eCode[7:0], "R2", "evCode vs model", evCode, eCode);
      check(irqStart == eStart, "R9", "irqStart vs model", irqStart, eStart);
      check(irqStop == eStop, "R9", "irqStop vs model", irqStop, eStop);
      check(irqHalf == eHalf, "R10", "irqHalf vs model", irqHalf, eHalf);
      check(irqRoll == eRoll, "R10", "irqRoll vs model", irqRoll, eRoll);
      if (evValid) gotQ.push_back(evCode);
      if (irqStart) nStart++;
      if (irqStop) nStop++;
      if (irqHalf) nHalf++;
      if (irqRoll) nRoll++;
    end
  end

  task automatic checkCodes(string req, bit prefixOnly);
    if (!prefixOnly)
      check(gotQ.size() == expQ.size(), req, "event count", gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size(); i++) begin
      if (i < gotQ.size())
        check(gotQ[i] == expQ[i], req, "event code", gotQ[i], expQ[i]);
      else
        check(0, req, "missing event", -1, expQ[i]);
    end
    gotQ = {};
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int idx, int code, int ts, int en, int dis);
    @(negedge clk);
    wrEn = 1; wrAddr = idx[ADDR_W-1:0]; wrCode = code[7:0]; wrTs = ts[TS_W-1:0];
    wrEnMask = en[MASK_N-1:0]; wrDisMask = dis[MASK_N-1:0];
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic pulseEnable();  @(negedge clk); ctlEnable = 1;  @(negedge clk); ctlEnable = 0;  endtask
  task automatic pulseDisable(); @(negedge clk); ctlDisable = 1; @(negedge clk); ctlDisable = 0; endtask
  task automatic pulseReset();   @(negedge clk); ctlReset = 1;   @(negedge clk); ctlReset = 0;   endtask
  task automatic pulseTrig();    @(negedge clk); trigger = 1;    @(negedge clk); trigger = 0;    endtask

  task automatic loadBasic();
    wr(0, 8'h10, 2, 0, 0);
    wr(1, 8'h11, 3, 0, 0);
    wr(2, 8'h00, 4, 0, 0);
    wr(3, 8'h12, 4, 0, 0);
    wr(4, 8'h13, 9, 0, 0);
    wr(5, 8'h7F, 12, 0, 0);
    tick(2);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int s0;
    tick(3);
    check(evValid == 0 && evCode == 0, "R2", "evValid/evCode in reset", evValid, 0);
    check({irqStart, irqStop, irqHalf, irqRoll} == 4'b0, "R9", "irq in reset",
          {irqStart, irqStop, irqHalf, irqRoll}, 0);
    rstN = 1;
    tick(2);

    // R1 R2 R4 R5: single mode, filler skipped, end marker not sent
    mode = 2'd0;
    loadBasic();
    pulseEnable();
    pulseTrig();
    tick(20);
    expQ = {8'h10, 8'h11, 8'h12, 8'h13};
    checkCodes("R1", 0);
    check(nStop == 1, "R9", "stop count", nStop, 1);
    s0 = nStart;
    pulseTrig();           // enable was dropped: must be ignored (R5)
    tick(20);
    check(nStart == s0, "R5", "trigger after single end", nStart, s0);
    expQ = {};
    checkCodes("R5", 0);

    // R6: recycle runs two passes without a new trigger
    mode = 2'd1;
    pulseEnable();
    pulseTrig();
    tick(40);
    expQ = {8'h10, 8'h11, 8'h12, 8'h13, 8'h10, 8'h11, 8'h12, 8'h13};
    checkCodes("R6", 1);
    check(nStart == s0 + 1, "R6", "single start in recycle", nStart, s0 + 1);
    // R8: disable holds, later resume
    pulseDisable();
    tick(20);
    expQ = {};
    checkCodes("R8", 0);
    pulseEnable();
    pulseTrig();
    tick(10);
    pulseReset();
    tick(3);
    gotQ = {};

    // R7 R12: retrigger mode, trigger during run ignored
    mode = 2'd2;
    s0 = nStart;
    pulseEnable();
    pulseTrig();
    tick(4);
    pulseTrig();
    tick(20);
    expQ = {8'h10, 8'h11, 8'h12, 8'h13};
    checkCodes("R12", 0);
    check(nStart == s0 + 1, "R12", "start count with mid-run trigger", nStart, s0 + 1);
    pulseTrig();
    tick(20);
    expQ = {8'h10, 8'h11, 8'h12, 8'h13};
    checkCodes("R7", 0);
    check(nStart == s0 + 2, "R7", "retrigger start count", nStart, s0 + 2);

    // R11: masks (still retrigger mode, still enabled)
    wr(0, 8'h21, 1, 4'b0001, 4'b0000);
    wr(1, 8'h22, 2, 4'b0000, 4'b0010);
    wr(2, 8'h23, 3, 4'b0100, 4'b1000);
    wr(3, 8'h7F, 5, 0, 0);
    tick(2);
    hwMask = 4'b0001; swMask = 4'b0000;
    pulseTrig(); tick(12);
    expQ = {8'h21, 8'h22};
    checkCodes("R11", 0);
    hwMask = 4'b1000; swMask = 4'b0110;
    pulseTrig(); tick(12);
    expQ = {};
    checkCodes("R11", 0);
    hwMask = 4'b0101; swMask = 4'b0000;
    pulseTrig(); tick(12);
    expQ = {8'h21, 8'h22, 8'h23};
    checkCodes("R11", 0);
    hwMask = 0;

    // R3: filler at all-ones bridges a counter wrap
    pulseReset();
    mode = 2'd0;
    wr(0, 8'h00, 255, 0, 0);
    wr(1, 8'h31, 2, 0, 0);
    wr(2, 8'h7F, 4, 0, 0);
    tick(2);
    pulseEnable();
    pulseTrig();
    tick(250);
    check(gotQ.size() == 0, "R3", "nothing before wrap", gotQ.size(), 0);
    tick(20);
    expQ = {8'h31};
    checkCodes("R3", 0);

    // R10: pointer crosses the middle and wraps
    for (int i = 0; i < DEPTH; i++) wr(i, 8'h40 + i, i, 0, 0);
    tick(2);
    s0 = nRoll;
    pulseEnable();
    pulseTrig();
    tick(38);
    pulseDisable();
    tick(3);
    check(nHalf == 1, "R10", "half pulses", nHalf, 1);
    check(nRoll == s0 + 1, "R10", "roll pulses", nRoll, s0 + 1);
    gotQ = {};

    // R8: reset beats enable, then restart from slot 0
    s0 = nStart;
    @(negedge clk); ctlEnable = 1; ctlReset = 1;
    @(negedge clk); ctlEnable = 0; ctlReset = 0;
    pulseTrig();
    tick(5);
    check(nStart == s0, "R8", "reset priority over enable", nStart, s0);
    pulseEnable();
    pulseTrig();
    tick(4);
    pulseDisable();
    tick(2);
    expQ = {8'h40};
    checkCodes("R8", 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule